// File: doc/BRIEF.md
# Self-Refreshing Panel Timing Controller

This block drives a TFT panel raster. It produces a line sync, a frame sync, a data-enable and the coordinates of each active pixel, and it presents one RGB word per clock while data-enable is high. The pixels come from one of two places. In live mode they come from a valid/ready source stream, and each accepted word is also written into an external frame store. In hold mode the source stream is never asked for data, so the upstream link can sit idle. The panel is then refreshed from the frame store alone, frame after frame, which keeps the image from fading.

A third mode, partial update, takes from the stream only the pixels that fall inside an inclusive rectangle (x start/end, y start/end). Those pixels are written to the store and shown. Every other position is read back from the store. In hold mode a programmable number of extra blanking lines is added after the vertical front porch, which lowers the refresh rate without touching the active or horizontal timing. The default timing is 320 active pixels, a 12-clock line sync and 400 clocks per line. With 240 active lines and the default vertical porches, a pixel clock of about 6.3 MHz gives roughly 60 frames per second.

The frame store is an external single-port synchronous RAM with a read latency of one clock. On a clock where a stream word is accepted the port writes; on every other clock it reads. Stream rules: `s_ready` depends only on the raster position and the frame's mode, never on `s_valid`. A word transfers on a clock where both are high. The source must present the words in raster order, either of the whole frame or of the rectangle. A ready slot with `s_valid` low is lost: that position shows its stored value and the store is left unchanged. Mode, rectangle, stretch and all porch and sync widths are sampled only on the last clock of a frame.

Top module: `psr_tcon`

## Requirements
- R1: While `rst_n` is low, `lcd_hsync`, `lcd_vsync`, `lcd_de`, `s_ready` and `mem_we` are all 0.
- R2: Each line lasts hsync+hbp+H_ACTIVE+hfp clocks. `lcd_hsync` is high for the first `cfg_hsync` clocks of each line. `lcd_de` rises `cfg_hsync`+`cfg_hbp` clocks after the line-sync rise and stays high for exactly H_ACTIVE clocks.
- R3: `lcd_vsync` is high for `cfg_vsync` whole lines. Each frame carries V_ACTIVE lines with data-enable. A live or partial frame lasts (vsync+vbp+V_ACTIVE+vfp) lines.
- R4: Live mode (`src_mode`=0): `s_ready` is high on every active pixel and only there. The k-th accepted word is shown at x=k mod H_ACTIVE, y=k div H_ACTIVE and is written to the store at address y*H_ACTIVE+x. `lcd_x`/`lcd_y` give the pixel's coordinates while `lcd_de` is high.
- R5: Hold mode (`src_mode`=1 or 3): `s_ready` and `mem_we` stay 0 for the whole frame, and every active pixel shows the store's last written value for its position.
- R6: Partial mode (`src_mode`=2): `s_ready` is high only on active pixels with `upd_x0`<=x<=`upd_x1` and `upd_y0`<=y<=`upd_y1`. Accepted words fill that rectangle in raster order and are shown and stored. All other positions show their stored values.
- R7: A hold frame lasts `cfg_vstretch` lines longer than a live frame of the same timing. `cfg_vstretch` has no effect on live or partial frames.
- R8: Changes to the mode, rectangle, stretch or timing inputs during a frame do not affect that frame. They take effect from the next frame.
- R9: In a ready slot where `s_valid` is low, nothing transfers and nothing is written. That position shows its previously stored value, and the next word goes to the next slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_hsync | input | CFG_W | Line sync width in clocks |
| cfg_hbp | input | CFG_W | Horizontal back porch in clocks |
| cfg_hfp | input | CFG_W | Horizontal front porch in clocks |
| cfg_vsync | input | CFG_W | Frame sync width in lines |
| cfg_vbp | input | CFG_W | Vertical back porch in lines |
| cfg_vfp | input | CFG_W | Vertical front porch in lines |
| cfg_vstretch | input | VC_W | Extra blanking lines in hold frames |
| src_mode | input | 2 | 0 live, 2 partial, 1 or 3 hold |
| upd_x0 | input | HC_W | Rectangle first column |
| upd_x1 | input | HC_W | Rectangle last column |
| upd_y0 | input | VC_W | Rectangle first row |
| upd_y1 | input | VC_W | Rectangle last row |
| s_valid | input | 1 | Source word valid |
| s_ready | output | 1 | Block takes a word this clock |
| s_data | input | PIX_W | Source RGB word |
| mem_addr | output | ADDR_W | Frame store address |
| mem_we | output | 1 | Frame store write strobe |
| mem_wdata | output | PIX_W | Frame store write data |
| mem_rdata | input | PIX_W | Frame store read data, one clock after the address |
| lcd_hsync | output | 1 | Line sync, active high |
| lcd_vsync | output | 1 | Frame sync, active high |
| lcd_de | output | 1 | Active pixel enable |
| lcd_x | output | HC_W | Column of the shown pixel |
| lcd_y | output | VC_W | Row of the shown pixel |
| lcd_pix | output | PIX_W | RGB word shown |

## Verification
The bench sweeps a 320x4 raster through a scripted series of live, hold and partial frames. It compares every active pixel with a shadow of the store that it keeps from the words it delivered, and it times every sync edge and data-enable run. The rectangles include a single rightmost column and a full bottom row. A design that compares the rectangle bounds off by one would take too many or too few words, or show stale corner pixels. A design that drops the store write in live mode would show old content in the next hold frame. One live frame leaves some ready slots empty. A design that writes or shows the empty slot would corrupt those positions, and one that waits for the word would shift every later pixel. Stretch and horizontal timing are changed partway through a frame, so a design that applies them at once or also stretches live frames would give wrong frame or line lengths.

// File: rtl/psr_pkg.sv
package psr_pkg;

  typedef enum logic [1:0] {
    SRC_LIVE = 2'd0,
    SRC_HOLD = 2'd1,
    SRC_PART = 2'd2
  } src_e;

  // Codes 1 and 3 both mean hold.
  function automatic src_e decode_mode(input logic [1:0] code);
    case (code)
      2'd0:    decode_mode = SRC_LIVE;
      2'd2:    decode_mode = SRC_PART;
      default: decode_mode = SRC_HOLD;
    endcase
  endfunction

endpackage

// File: rtl/psr_hvgen.sv
module psr_hvgen #(
  parameter int H_ACTIVE = 320,
  parameter int V_ACTIVE = 240,
  parameter int HC_W     = 10,
  parameter int VC_W     = 10,
  parameter int CFG_W    = 8,
  parameter int D_HS     = 12,
  parameter int D_HBP    = 38,
  parameter int D_HFP    = 30,
  parameter int D_VS     = 3,
  parameter int D_VBP    = 12,
  parameter int D_VFP    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_hsync,
  input  logic [CFG_W-1:0] cfg_hbp,
  input  logic [CFG_W-1:0] cfg_hfp,
  input  logic [CFG_W-1:0] cfg_vsync,
  input  logic [CFG_W-1:0] cfg_vbp,
  input  logic [CFG_W-1:0] cfg_vfp,
  input  logic [VC_W-1:0]  cfg_vstretch,
  input  logic             hold_i,
  output logic             frame_last,
  output logic             hs0,
  output logic             vs0,
  output logic             de0,
  output logic [HC_W-1:0]  x0,
  output logic [VC_W-1:0]  y0
);

  logic [HC_W-1:0]  hcnt, h_start, htot;
  logic [VC_W-1:0]  vcnt, v_start, vtot;
  logic [CFG_W-1:0] hs_q, hbp_q, hfp_q, vs_q, vbp_q, vfp_q;
  logic [VC_W-1:0]  str_q;
  logic             line_last, h_in, v_in;

  assign h_start = HC_W'(hs_q) + HC_W'(hbp_q);
  assign htot    = h_start + HC_W'(H_ACTIVE) + HC_W'(hfp_q);
  assign v_start = VC_W'(vs_q) + VC_W'(vbp_q);
  // Stretch lines sit after the front porch, in hold frames only.
  assign vtot    = v_start + VC_W'(V_ACTIVE) + VC_W'(vfp_q) + (hold_i ? str_q : '0);

  assign line_last  = (hcnt == htot - HC_W'(1));
  assign frame_last = line_last && (vcnt == vtot - VC_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt  <= '0;
      vcnt  <= '0;
      hs_q  <= CFG_W'(D_HS);
      hbp_q <= CFG_W'(D_HBP);
      hfp_q <= CFG_W'(D_HFP);
      vs_q  <= CFG_W'(D_VS);
      vbp_q <= CFG_W'(D_VBP);
      vfp_q <= CFG_W'(D_VFP);
      str_q <= '0;
    end else begin
      hcnt <= line_last ? '0 : hcnt + HC_W'(1);
      if (line_last) vcnt <= frame_last ? '0 : vcnt + VC_W'(1);
      if (frame_last) begin
        hs_q  <= cfg_hsync;
        hbp_q <= cfg_hbp;
        hfp_q <= cfg_hfp;
        vs_q  <= cfg_vsync;
        vbp_q <= cfg_vbp;
        vfp_q <= cfg_vfp;
        str_q <= cfg_vstretch;
      end
    end
  end

  assign h_in = (hcnt >= h_start) && (hcnt < h_start + HC_W'(H_ACTIVE));
  assign v_in = (vcnt >= v_start) && (vcnt < v_start + VC_W'(V_ACTIVE));
  assign hs0  = hcnt < HC_W'(hs_q);
  assign vs0  = vcnt < VC_W'(vs_q);
  assign de0  = h_in && v_in;
  assign x0   = hcnt - h_start;
  assign y0   = vcnt - v_start;

endmodule

// File: rtl/psr_srcsel.sv
module psr_srcsel
  import psr_pkg::*;
#(
  parameter int HC_W = 10,
  parameter int VC_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_last,
  input  logic [1:0]      mode_i,
  input  logic [HC_W-1:0] rx0_i,
  input  logic [HC_W-1:0] rx1_i,
  input  logic [VC_W-1:0] ry0_i,
  input  logic [VC_W-1:0] ry1_i,
  input  logic            de0,
  input  logic [HC_W-1:0] x0,
  input  logic [VC_W-1:0] y0,
  input  logic            s_valid,
  output logic            hold_o,
  output logic            s_ready,
  output logic            take_o
);

  src_e            mode_q;
  logic [HC_W-1:0] rx0_q, rx1_q;
  logic [VC_W-1:0] ry0_q, ry1_q;
  logic            in_rect;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= SRC_LIVE;
      rx0_q  <= '0;
      rx1_q  <= '0;
      ry0_q  <= '0;
      ry1_q  <= '0;
    end else if (frame_last) begin
      mode_q <= decode_mode(mode_i);
      rx0_q  <= rx0_i;
      rx1_q  <= rx1_i;
      ry0_q  <= ry0_i;
      ry1_q  <= ry1_i;
    end
  end

  assign in_rect = (x0 >= rx0_q) && (x0 <= rx1_q) && (y0 >= ry0_q) && (y0 <= ry1_q);
  assign hold_o  = (mode_q == SRC_HOLD);
  assign s_ready = de0 && ((mode_q == SRC_LIVE) || ((mode_q == SRC_PART) && in_rect));
  assign take_o  = s_ready && s_valid;

  // R8: the frame's source choice only moves at the frame boundary
  a_r8_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_last |=> $stable(mode_q));

endmodule

// File: rtl/psr_pixout.sv
module psr_pixout #(
  parameter int HC_W  = 10,
  parameter int VC_W  = 10,
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hs0,
  input  logic             vs0,
  input  logic             de0,
  input  logic [HC_W-1:0]  x0,
  input  logic [VC_W-1:0]  y0,
  input  logic             take,
  input  logic [PIX_W-1:0] s_data,
  input  logic [PIX_W-1:0] mem_rdata,
  output logic             lcd_hsync,
  output logic             lcd_vsync,
  output logic             lcd_de,
  output logic [HC_W-1:0]  lcd_x,
  output logic [VC_W-1:0]  lcd_y,
  output logic [PIX_W-1:0] lcd_pix
);

  // Stage 1 waits alongside the store read; stage 2 picks the pixel.
  logic             hs1, vs1, de1, take1;
  logic [HC_W-1:0]  x1;
  logic [VC_W-1:0]  y1;
  logic [PIX_W-1:0] live1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs1 <= 1'b0; vs1 <= 1'b0; de1 <= 1'b0; take1 <= 1'b0;
      x1 <= '0; y1 <= '0; live1 <= '0;
      lcd_hsync <= 1'b0; lcd_vsync <= 1'b0; lcd_de <= 1'b0;
      lcd_x <= '0; lcd_y <= '0; lcd_pix <= '0;
    end else begin
      hs1   <= hs0;
      vs1   <= vs0;
      de1   <= de0;
      take1 <= take;
      x1    <= de0 ? x0 : '0;
      y1    <= de0 ? y0 : '0;
      live1 <= s_data;
      lcd_hsync <= hs1;
      lcd_vsync <= vs1;
      lcd_de    <= de1;
      lcd_x     <= x1;
      lcd_y     <= y1;
      lcd_pix   <= de1 ? (take1 ? live1 : mem_rdata) : '0;
    end
  end

  // R3: no active pixel inside the frame sync
  a_r3_vsync_blanks_de: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_vsync |-> !lcd_de);
  // R2: no active pixel inside the line sync
  a_r2_hsync_blanks_de: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_de |-> !lcd_hsync);

endmodule

// File: rtl/psr_tcon.sv
module psr_tcon #(
  parameter int H_ACTIVE = 320,
  parameter int V_ACTIVE = 240,
  parameter int PIX_W    = 24,
  parameter int HC_W     = 10,
  parameter int VC_W     = 10,
  parameter int CFG_W    = 8,
  parameter int D_HS     = 12,
  parameter int D_HBP    = 38,
  parameter int D_HFP    = 30,
  parameter int D_VS     = 3,
  parameter int D_VBP    = 12,
  parameter int D_VFP    = 8,
  localparam int ADDR_W  = $clog2(H_ACTIVE * V_ACTIVE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  cfg_hsync,
  input  logic [CFG_W-1:0]  cfg_hbp,
  input  logic [CFG_W-1:0]  cfg_hfp,
  input  logic [CFG_W-1:0]  cfg_vsync,
  input  logic [CFG_W-1:0]  cfg_vbp,
  input  logic [CFG_W-1:0]  cfg_vfp,
  input  logic [VC_W-1:0]   cfg_vstretch,
  input  logic [1:0]        src_mode,
  input  logic [HC_W-1:0]   upd_x0,
  input  logic [HC_W-1:0]   upd_x1,
  input  logic [VC_W-1:0]   upd_y0,
  input  logic [VC_W-1:0]   upd_y1,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [PIX_W-1:0]  s_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [PIX_W-1:0]  mem_wdata,
  input  logic [PIX_W-1:0]  mem_rdata,
  output logic              lcd_hsync,
  output logic              lcd_vsync,
  output logic              lcd_de,
  output logic [HC_W-1:0]   lcd_x,
  output logic [VC_W-1:0]   lcd_y,
  output logic [PIX_W-1:0]  lcd_pix
);

  logic            frame_last, hs0, vs0, de0, hold, take;
  logic [HC_W-1:0] x0;
  logic [VC_W-1:0] y0;

  psr_hvgen #(
    .H_ACTIVE(H_ACTIVE), .V_ACTIVE(V_ACTIVE), .HC_W(HC_W), .VC_W(VC_W), .CFG_W(CFG_W),
    .D_HS(D_HS), .D_HBP(D_HBP), .D_HFP(D_HFP), .D_VS(D_VS), .D_VBP(D_VBP), .D_VFP(D_VFP)
  ) u_hv (
    .clk(clk), .rst_n(rst_n),
    .cfg_hsync(cfg_hsync), .cfg_hbp(cfg_hbp), .cfg_hfp(cfg_hfp),
    .cfg_vsync(cfg_vsync), .cfg_vbp(cfg_vbp), .cfg_vfp(cfg_vfp),
    .cfg_vstretch(cfg_vstretch), .hold_i(hold),
    .frame_last(frame_last), .hs0(hs0), .vs0(vs0), .de0(de0), .x0(x0), .y0(y0)
  );

  psr_srcsel #(.HC_W(HC_W), .VC_W(VC_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .frame_last(frame_last), .mode_i(src_mode),
    .rx0_i(upd_x0), .rx1_i(upd_x1), .ry0_i(upd_y0), .ry1_i(upd_y1),
    .de0(de0), .x0(x0), .y0(y0), .s_valid(s_valid),
    .hold_o(hold), .s_ready(s_ready), .take_o(take)
  );

  // One port: write when a word is taken, read otherwise.
  assign mem_addr  = de0 ? (ADDR_W'(y0) * ADDR_W'(H_ACTIVE) + ADDR_W'(x0)) : '0;
  assign mem_we    = take;
  assign mem_wdata = s_data;

  psr_pixout #(.HC_W(HC_W), .VC_W(VC_W), .PIX_W(PIX_W)) u_out (
    .clk(clk), .rst_n(rst_n), .hs0(hs0), .vs0(vs0), .de0(de0), .x0(x0), .y0(y0),
    .take(take), .s_data(s_data), .mem_rdata(mem_rdata),
    .lcd_hsync(lcd_hsync), .lcd_vsync(lcd_vsync), .lcd_de(lcd_de),
    .lcd_x(lcd_x), .lcd_y(lcd_y), .lcd_pix(lcd_pix)
  );

  // R4: the stream is only asked for data on active pixels
  a_r4_ready_only_active: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> de0);
  // R5: a hold frame never writes the store
  a_r5_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !mem_we);

endmodule

// File: tb/psr_tcon_test.sv
`timescale 1ns/1ps
module psr_tcon_test;

  localparam int H = 320;
  localparam int V = 4;
  localparam int VS = 1, VBP = 1, VFP = 1;
  localparam int NF = 14;
  localparam int AW = $clog2(H * V);

  logic clk = 1'b0;
  logic rst_n;
  logic [7:0] cfg_hsync, cfg_hbp, cfg_hfp, cfg_vsync, cfg_vbp, cfg_vfp;
  logic [9:0] cfg_vstretch;
  logic [1:0] src_mode;
  logic [9:0] upd_x0, upd_x1, upd_y0, upd_y1;
  logic s_valid, s_ready, mem_we;
  logic [23:0] s_data, mem_wdata, mem_rdata, lcd_pix;
  logic [AW-1:0] mem_addr;
  logic lcd_hsync, lcd_vsync, lcd_de;
  logic [9:0] lcd_x, lcd_y;

  always #10 clk = ~clk;

  psr_tcon #(.H_ACTIVE(H), .V_ACTIVE(V), .D_VS(VS), .D_VBP(VBP), .D_VFP(VFP)) uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_hsync(cfg_hsync), .cfg_hbp(cfg_hbp), .cfg_hfp(cfg_hfp),
    .cfg_vsync(cfg_vsync), .cfg_vbp(cfg_vbp), .cfg_vfp(cfg_vfp),
    .cfg_vstretch(cfg_vstretch), .src_mode(src_mode),
    .upd_x0(upd_x0), .upd_x1(upd_x1), .upd_y0(upd_y0), .upd_y1(upd_y1),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .lcd_hsync(lcd_hsync), .lcd_vsync(lcd_vsync), .lcd_de(lcd_de),
    .lcd_x(lcd_x), .lcd_y(lcd_y), .lcd_pix(lcd_pix)
  );

  // External frame store model: one port, one clock read latency.
  logic [23:0] ram [0:H*V-1];
  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    mem_rdata <= ram[mem_addr];
  end

  logic [23:0] shadow [0:H*V-1];
  int p_mode[NF], p_tag[NF], p_x0[NF], p_x1[NF], p_y0[NF], p_y1[NF];
  int p_hs[NF], p_hbp[NF], p_hfp[NF], p_str[NF], p_drop[NF];

  int n_chk = 0, n_bad = 0;
  int cyc, cur, fstart, vs_rise, vs_w, last_hsr, de_rise, de_k, lines_de, h_bad;
  int slot, ready_cnt, acc, mism;
  longint mm_act, mm_exp;
  bit pv, ph, pd, done;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic plan(input int i, input int m, input int x0, input int x1,
                      input int y0, input int y1, input int hs, input int hbp,
                      input int str, input int drop);
    p_mode[i] = m; p_tag[i] = i + 1; p_x0[i] = x0; p_x1[i] = x1; p_y0[i] = y0; p_y1[i] = y1;
    p_hs[i] = hs; p_hbp[i] = hbp; p_hfp[i] = 30; p_str[i] = str; p_drop[i] = drop;
  endtask

  task automatic apply(input int i);
    cfg_hsync = 8'(p_hs[i]); cfg_hbp = 8'(p_hbp[i]); cfg_hfp = 8'(p_hfp[i]);
    cfg_vsync = 8'(VS); cfg_vbp = 8'(VBP); cfg_vfp = 8'(VFP);
    cfg_vstretch = 10'(p_str[i]); src_mode = 2'(p_mode[i]);
    upd_x0 = 10'(p_x0[i]); upd_x1 = 10'(p_x1[i]); upd_y0 = 10'(p_y0[i]); upd_y1 = 10'(p_y1[i]);
  endtask

  function automatic int htot(input int i);
    return p_hs[i] + p_hbp[i] + H + p_hfp[i];
  endfunction

  function automatic bit is_hold(input int i);
    return (p_mode[i] == 1) || (p_mode[i] == 3);
  endfunction

  function automatic string mode_req(input int i);
    if (p_drop[i] != 0) return "R9";
    if (is_hold(i)) return "R5";
    if (p_mode[i] == 2) return "R6";
    return "R4";
  endfunction

  task automatic finalize(input int i);
    int len_lines, exp_ready, exp_acc;
    string tim;
    len_lines = VS + VBP + V + VFP + (is_hold(i) ? p_str[i] : 0);
    tim = (i == 9 || i == 10) ? "R8" : "R2";
    chk((cyc - fstart) == htot(i) * len_lines, is_hold(i) ? "R7" : "R3",
        $sformatf("frame %0d length", i), cyc - fstart, htot(i) * len_lines);
    chk(vs_w == VS * htot(i), "R3", $sformatf("frame %0d vsync width", i), vs_w, VS * htot(i));
    chk(lines_de == V, "R3", $sformatf("frame %0d active lines", i), lines_de, V);
    chk(h_bad == 0, tim, $sformatf("frame %0d line timing errors", i), h_bad, 0);
    chk(mism == 0, mode_req(i), $sformatf("frame %0d pixel mismatches (first act/exp %0h/%0h)",
        i, mm_act, mm_exp), mism, 0);
    if (is_hold(i)) exp_ready = 0;
    else if (p_mode[i] == 2) exp_ready = (p_x1[i] - p_x0[i] + 1) * (p_y1[i] - p_y0[i] + 1);
    else exp_ready = H * V;
    chk(ready_cnt == exp_ready, mode_req(i), $sformatf("frame %0d ready slots", i),
        ready_cnt, exp_ready);
    exp_acc = exp_ready;
    if (p_drop[i] != 0) for (int k = 0; k < exp_ready; k++) if (k % 7 == 3) exp_acc--;
    chk(acc == exp_acc, mode_req(i), $sformatf("frame %0d accepted words", i), acc, exp_acc);
  endtask

  initial begin
    int x, y, w, idx;
    logic [23:0] val;
    for (int k = 0; k < H * V; k++) shadow[k] = '0;
    //   i  mode x0   x1   y0 y1 hs  hbp str drop
    plan(0,  0,   0,   0,  0, 0, 12, 38, 3, 0);
    plan(1,  0,   0,   0,  0, 0, 12, 38, 3, 0);
    plan(2,  1,   0,   0,  0, 0, 12, 38, 3, 0);
    plan(3,  1,   0,   0,  0, 0, 12, 38, 3, 0);
    plan(4,  2,   5,  20,  1, 2, 12, 38, 3, 0);
    plan(5,  1,   0,   0,  0, 0, 12, 38, 3, 0);
    plan(6,  2, 319, 319,  0, 3, 12, 38, 3, 0);
    plan(7,  1,   0,   0,  0, 0, 12, 38, 3, 0);
    plan(8,  0,   0,   0,  0, 0, 12, 38, 3, 1);
    plan(9,  1,   0,   0,  0, 0, 12, 38, 3, 0);
    plan(10, 0,   0,   0,  0, 0,  8, 42, 3, 0);
    plan(11, 3,   0,   0,  0, 0,  8, 42, 1, 0);
    plan(12, 2,   0, 319,  3, 3,  8, 42, 3, 0);
    plan(13, 1,   0,   0,  0, 0,  8, 42, 3, 0);
    apply(0);
    s_valid = 1'b0; s_data = '0; rst_n = 1'b0;
    repeat (4) @(negedge clk);
    // R1: everything quiet while reset is held
    chk(!lcd_hsync && !lcd_vsync && !lcd_de && !s_ready && !mem_we, "R1",
        "outputs during reset", {lcd_hsync, lcd_vsync, lcd_de, s_ready, mem_we}, 0);
    rst_n = 1'b1;
    cyc = 0; cur = -1; pv = 0; ph = 0; pd = 0; done = 0;
    last_hsr = 0; vs_rise = 0; fstart = 0;
    while (!done) begin
      @(negedge clk);
      cyc++;
      if (cyc > 150000) begin
        chk(0, "R3", "watchdog expired before last frame", cur, NF - 1);
        done = 1;
      end else begin
        if (lcd_vsync && !pv) begin
          if (cur >= 0) finalize(cur);
          cur++;
          if (cur == NF - 1) done = 1;
          else begin
            fstart = cyc; vs_rise = cyc; vs_w = 0; de_k = 0; lines_de = 0; h_bad = 0;
            slot = 0; ready_cnt = 0; acc = 0; mism = 0; mm_act = 0; mm_exp = 0;
            apply(cur + 1);  // R8: takes effect only after this frame
          end
        end
        if (!done && cur >= 0) begin
          if (!lcd_vsync && pv) vs_w = cyc - vs_rise;
          if (lcd_hsync && !ph) begin
            if (!(lcd_vsync && !pv) && (cyc - last_hsr) != htot(cur)) h_bad++;
            last_hsr = cyc;
          end
          if (!lcd_hsync && ph && (cyc - last_hsr) != p_hs[cur]) h_bad++;
          if (lcd_de && !pd) begin
            de_rise = cyc;
            if ((cyc - last_hsr) != p_hs[cur] + p_hbp[cur]) h_bad++;
          end
          if (!lcd_de && pd) begin
            lines_de++;
            if ((cyc - de_rise) != H) h_bad++;
          end
          if (lcd_de) begin
            x = de_k % H; y = de_k / H; idx = y * H + x;
            if (int'(lcd_x) != x || int'(lcd_y) != y || lcd_pix !== shadow[idx]) begin
              if (mism == 0) begin
                mm_act = {lcd_y, lcd_x, lcd_pix};
                mm_exp = {10'(y), 10'(x), shadow[idx]};
              end
              mism++;
            end
            de_k++;
          end
          // source: present the word for the slot the block asks for next
          if (s_ready) begin
            ready_cnt++;
            if (p_mode[cur] == 2) begin
              w = p_x1[cur] - p_x0[cur] + 1;
              x = p_x0[cur] + slot % w; y = p_y0[cur] + slot / w;
            end else begin
              x = slot % H; y = slot / H;
            end
            val = 24'((p_tag[cur] % 64) * 262144 + (y % 256) * 1024 + x);
            s_data = val;
            s_valid = !(p_drop[cur] != 0 && (slot % 7) == 3);
            if (s_valid) begin
              shadow[y * H + x] = val;
              acc++;
            end
            slot++;
          end
        end
        pv = lcd_vsync; ph = lcd_hsync; pd = lcd_de;
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule